// File: doc/BRIEF.md
# Shared Pad Function Arbiter

This block chooses, for every shared pad of an audio codec, which function owns the pad. There are three pad families. Microphone pads carry either a digital-microphone clock or data signal, or a general-purpose I/O. Reference pads carry either a reference-voltage output or a GPIO. One combined pad can act as amplifier power-down, S/PDIF receive, S/PDIF transmit or GPIO. Each family has its own fixed priority rule. The combined pad also has a tie rule for the case where both direction enables are set.

The inputs are a group-wide GPIO enable, a GPIO enable and a direction bit for each pad, the input-enable of the microphone port, and the input and output enables of the combined pad. For each pad the block registers a 2-bit function code and an output enable. It also registers a pull-down control for each microphone pad and one mute flag for the microphone path. Every output updates on the clock edge after its inputs change. Reference generation and S/PDIF serialisation sit outside this block.

Top module: `pad_mux_ctrl`

## Requirements
- R1: While rst_ni is low, the block shows these values: every microphone pad has code 0 with output enable 0 and pull-down 1, and the mute flag is 1. Every reference pad has code 0 with output enable 1. The combined pad has code 0 (amplifier power-down) with output enable 1.
- R2: Function codes are 2 bits per pad, with pad i at bits [2i+1:2i]: 0 = native (power-down, reference or microphone), 1 = GPIO, 2 = S/PDIF receive, 3 = S/PDIF transmit. A pad's GPIO is active only when the group enable and that pad's GPIO enable are both 1. An active GPIO on the combined pad gives code 1, whatever the input and output enables are.
- R3: When the combined pad's GPIO is not active, the pad takes code 2 if only its input enable is set. It takes code 3 if only its output enable is set, and code 0 if neither is set.
- R4: When the combined pad's GPIO is not active and both of its enables are set, it takes code 2 (S/PDIF receive).
- R5: A reference pad with an active GPIO takes code 1. Otherwise it takes code 0 with output enable 1.
- R6: Each microphone pad's pull-down is 1 exactly when the group GPIO enable is 0.
- R7: The mute flag is 1 when the microphone port input enable is 0 or when any microphone pad has an active GPIO. Otherwise it is 0.
- R8: Outputs change only on the rising clock edge that follows an input change. They do not change before that edge.
- R9: A pad's output enable is 1 only for code 3, for code 0 on a reference pad or the combined pad, or for an active GPIO whose direction bit is 1. The direction bit is 1 for output.
- R10: A pad's GPIO enable has no effect while the group GPIO enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| gpio_grp_en_i | input | 1 | Group-wide GPIO enable |
| mic_gpio_en_i | input | N_MIC | GPIO enable per microphone pad |
| mic_gpio_dir_i | input | N_MIC | GPIO direction per microphone pad (1 = output) |
| mic_port_in_en_i | input | 1 | Microphone port input enable |
| vref_gpio_en_i | input | N_VREF | GPIO enable per reference pad |
| vref_gpio_dir_i | input | N_VREF | GPIO direction per reference pad |
| combo_gpio_en_i | input | 1 | GPIO enable of the combined pad |
| combo_gpio_dir_i | input | 1 | GPIO direction of the combined pad |
| combo_in_en_i | input | 1 | Combined pad input enable |
| combo_out_en_i | input | 1 | Combined pad output enable |
| mic_func_o | output | 2*N_MIC | Function code per microphone pad |
| mic_oe_o | output | N_MIC | Output enable per microphone pad |
| mic_pd_o | output | N_MIC | Pull-down control per microphone pad |
| mic_mute_o | output | 1 | Microphone path mute |
| vref_func_o | output | 2*N_VREF | Function code per reference pad |
| vref_oe_o | output | N_VREF | Output enable per reference pad |
| combo_func_o | output | 2 | Function code of the combined pad |
| combo_oe_o | output | 1 | Output enable of the combined pad |

## Verification
The bound checker compares each cycle's registered outputs with the inputs sampled one edge earlier. On every cycle it checks the GPIO priority on the combined pad and on the reference pads, the receive-wins tie rule, the pull-down rule, the mute conditions, and the absence of output drive while receiving. The bench's scenarios are the only place that shows the reset values. They also show that an output holds its old value in the half cycle before the capturing edge, and that the individual pad enables have no effect while the group enable is off.

// File: rtl/pad_mux_pkg.sv
package pad_mux_pkg;
  localparam int FN_W = 2;
  typedef enum logic [FN_W-1:0] {
    FN_NATIVE    = 2'd0,
    FN_GPIO      = 2'd1,
    FN_SPDIF_IN  = 2'd2,
    FN_SPDIF_OUT = 2'd3
  } pad_fn_e;
endpackage

// File: rtl/pad_gpio_sel.sv
module pad_gpio_sel
  import pad_mux_pkg::*;
#(
  parameter bit NATIVE_OE = 1'b0
) (
  input  logic    grp_en_i,
  input  logic    pin_en_i,
  input  logic    dir_i,
  output pad_fn_e fn_o,
  output logic    oe_o,
  output logic    gpio_act_o
);
  assign gpio_act_o = grp_en_i & pin_en_i;

  always_comb begin
    if (gpio_act_o) begin
      fn_o = FN_GPIO;
      oe_o = dir_i;
    end else begin
      fn_o = FN_NATIVE;
      oe_o = NATIVE_OE;
    end
  end
endmodule

// File: rtl/combo_pad_sel.sv
module combo_pad_sel
  import pad_mux_pkg::*;
(
  input  logic    grp_en_i,
  input  logic    pin_en_i,
  input  logic    dir_i,
  input  logic    in_en_i,
  input  logic    out_en_i,
  output pad_fn_e fn_o,
  output logic    oe_o
);
  // priority: GPIO > receive (wins tie) > transmit > power-down
  always_comb begin
    if (grp_en_i && pin_en_i) begin
      fn_o = FN_GPIO;
      oe_o = dir_i;
    end else if (in_en_i) begin
      fn_o = FN_SPDIF_IN;
      oe_o = 1'b0;
    end else if (out_en_i) begin
      fn_o = FN_SPDIF_OUT;
      oe_o = 1'b1;
    end else begin
      fn_o = FN_NATIVE;
      oe_o = 1'b1;
    end
  end
endmodule

// File: rtl/pad_mux_ctrl.sv
module pad_mux_ctrl
  import pad_mux_pkg::*;
#(
  parameter int N_MIC  = 3,
  parameter int N_VREF = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   gpio_grp_en_i,
  input  logic [N_MIC-1:0]       mic_gpio_en_i,
  input  logic [N_MIC-1:0]       mic_gpio_dir_i,
  input  logic                   mic_port_in_en_i,
  input  logic [N_VREF-1:0]      vref_gpio_en_i,
  input  logic [N_VREF-1:0]      vref_gpio_dir_i,
  input  logic                   combo_gpio_en_i,
  input  logic                   combo_gpio_dir_i,
  input  logic                   combo_in_en_i,
  input  logic                   combo_out_en_i,
  output logic [FN_W*N_MIC-1:0]  mic_func_o,
  output logic [N_MIC-1:0]       mic_oe_o,
  output logic [N_MIC-1:0]       mic_pd_o,
  output logic                   mic_mute_o,
  output logic [FN_W*N_VREF-1:0] vref_func_o,
  output logic [N_VREF-1:0]      vref_oe_o,
  output logic [FN_W-1:0]        combo_func_o,
  output logic                   combo_oe_o
);
  localparam int MIC_FW  = FN_W * N_MIC;
  localparam int VREF_FW = FN_W * N_VREF;

  logic [MIC_FW-1:0]  mic_fn_d;
  logic [N_MIC-1:0]   mic_oe_d, mic_act;
  logic [VREF_FW-1:0] vref_fn_d;
  logic [N_VREF-1:0]  vref_oe_d, vref_act;
  pad_fn_e            combo_fn_d;
  logic               combo_oe_d;

  for (genvar i = 0; i < N_MIC; i++) begin : g_mic
    pad_fn_e fn;
    pad_gpio_sel #(.NATIVE_OE(1'b0)) u_sel (
      .grp_en_i  (gpio_grp_en_i),
      .pin_en_i  (mic_gpio_en_i[i]),
      .dir_i     (mic_gpio_dir_i[i]),
      .fn_o      (fn),
      .oe_o      (mic_oe_d[i]),
      .gpio_act_o(mic_act[i])
    );
    assign mic_fn_d[FN_W*i +: FN_W] = fn;
  end

  for (genvar i = 0; i < N_VREF; i++) begin : g_vref
    pad_fn_e fn;
    pad_gpio_sel #(.NATIVE_OE(1'b1)) u_sel (
      .grp_en_i  (gpio_grp_en_i),
      .pin_en_i  (vref_gpio_en_i[i]),
      .dir_i     (vref_gpio_dir_i[i]),
      .fn_o      (fn),
      .oe_o      (vref_oe_d[i]),
      .gpio_act_o(vref_act[i])
    );
    assign vref_fn_d[FN_W*i +: FN_W] = fn;
  end

  combo_pad_sel u_combo (
    .grp_en_i(gpio_grp_en_i),
    .pin_en_i(combo_gpio_en_i),
    .dir_i   (combo_gpio_dir_i),
    .in_en_i (combo_in_en_i),
    .out_en_i(combo_out_en_i),
    .fn_o    (combo_fn_d),
    .oe_o    (combo_oe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mic_func_o   <= '0;
      mic_oe_o     <= '0;
      mic_pd_o     <= '1;
      mic_mute_o   <= 1'b1;
      vref_func_o  <= '0;
      vref_oe_o    <= '1;
      combo_func_o <= FN_NATIVE;
      combo_oe_o   <= 1'b1;
    end else begin
      mic_func_o   <= mic_fn_d;
      mic_oe_o     <= mic_oe_d;
      mic_pd_o     <= {N_MIC{~gpio_grp_en_i}};
      mic_mute_o   <= ~mic_port_in_en_i | (|mic_act);
      vref_func_o  <= vref_fn_d;
      vref_oe_o    <= vref_oe_d;
      combo_func_o <= combo_fn_d;
      combo_oe_o   <= combo_oe_d;
    end
  end
endmodule

// File: rtl/pad_mux_ctrl_chk.sv
module pad_mux_ctrl_chk #(
  parameter int N_MIC  = 3,
  parameter int N_VREF = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                gpio_grp_en_i,
  input logic [N_MIC-1:0]    mic_gpio_en_i,
  input logic [N_MIC-1:0]    mic_gpio_dir_i,
  input logic                mic_port_in_en_i,
  input logic [N_VREF-1:0]   vref_gpio_en_i,
  input logic [N_VREF-1:0]   vref_gpio_dir_i,
  input logic                combo_gpio_en_i,
  input logic                combo_gpio_dir_i,
  input logic                combo_in_en_i,
  input logic                combo_out_en_i,
  input logic [2*N_MIC-1:0]  mic_func_o,
  input logic [N_MIC-1:0]    mic_oe_o,
  input logic [N_MIC-1:0]    mic_pd_o,
  input logic                mic_mute_o,
  input logic [2*N_VREF-1:0] vref_func_o,
  input logic [N_VREF-1:0]   vref_oe_o,
  input logic [1:0]          combo_func_o,
  input logic                combo_oe_o
);
  p_combo_gpio_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(gpio_grp_en_i && combo_gpio_en_i)
    |-> combo_func_o == 2'd1 && combo_oe_o == $past(combo_gpio_dir_i));

  p_combo_tie_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(!(gpio_grp_en_i && combo_gpio_en_i) && combo_in_en_i && combo_out_en_i)
    |-> combo_func_o == 2'd2);

  p_rx_no_drive_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    combo_func_o == 2'd2 |-> !combo_oe_o);

  p_pulldown_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> mic_pd_o == {N_MIC{!$past(gpio_grp_en_i)}});

  p_mute_port_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && !$past(mic_port_in_en_i) |-> mic_mute_o);

  p_mute_gpio_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) && $past(gpio_grp_en_i && (|mic_gpio_en_i)) |-> mic_mute_o);

  for (genvar i = 0; i < N_VREF; i++) begin : g_vref
    p_vref_gpio_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && $past(gpio_grp_en_i && vref_gpio_en_i[i])
      |-> vref_func_o[2*i +: 2] == 2'd1 && vref_oe_o[i] == $past(vref_gpio_dir_i[i]));
    p_vref_native_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(rst_ni) && !$past(gpio_grp_en_i && vref_gpio_en_i[i])
      |-> vref_func_o[2*i +: 2] == 2'd0 && vref_oe_o[i]);
  end
endmodule

bind pad_mux_ctrl pad_mux_ctrl_chk #(.N_MIC(N_MIC), .N_VREF(N_VREF)) u_chk (.*);

// File: tb/pad_mux_ctrl_test.sv
module pad_mux_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;
  localparam int NV = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic grp = 0, port_in = 0, c_en = 0, c_dir = 0, c_in = 0, c_out = 0;
  logic [NM-1:0] m_en = '0, m_dir = '0;
  logic [NV-1:0] v_en = '0, v_dir = '0;
  logic [2*NM-1:0] mic_func;
  logic [NM-1:0] mic_oe, mic_pd;
  logic mic_mute;
  logic [2*NV-1:0] vref_func;
  logic [NV-1:0] vref_oe;
  logic [1:0] combo_func;
  logic combo_oe;

  int checks = 0, errors = 0;

  typedef struct {
    logic [2*NM-1:0] mf;
    logic [NM-1:0]   mo, mp;
    logic            mm;
    logic [2*NV-1:0] vf;
    logic [NV-1:0]   vo;
    logic [1:0]      cf;
    logic            co;
    string           tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pad_mux_ctrl #(.N_MIC(NM), .N_VREF(NV)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .gpio_grp_en_i(grp),
    .mic_gpio_en_i(m_en), .mic_gpio_dir_i(m_dir), .mic_port_in_en_i(port_in),
    .vref_gpio_en_i(v_en), .vref_gpio_dir_i(v_dir),
    .combo_gpio_en_i(c_en), .combo_gpio_dir_i(c_dir),
    .combo_in_en_i(c_in), .combo_out_en_i(c_out),
    .mic_func_o(mic_func), .mic_oe_o(mic_oe), .mic_pd_o(mic_pd), .mic_mute_o(mic_mute),
    .vref_func_o(vref_func), .vref_oe_o(vref_oe),
    .combo_func_o(combo_func), .combo_oe_o(combo_oe)
  );

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t model(string tag);
    exp_t e;
    logic act;
    e.tag = tag;
    e.mm = !port_in;
    for (int i = 0; i < NM; i++) begin
      act = grp & m_en[i];
      e.mf[2*i +: 2] = act ? 2'd1 : 2'd0;
      e.mo[i] = act ? m_dir[i] : 1'b0;
      e.mp[i] = !grp;
      if (act) e.mm = 1'b1;
    end
    for (int i = 0; i < NV; i++) begin
      act = grp & v_en[i];
      e.vf[2*i +: 2] = act ? 2'd1 : 2'd0;
      e.vo[i] = act ? v_dir[i] : 1'b1;
    end
    if (grp & c_en)  begin e.cf = 2'd1; e.co = c_dir; end
    else if (c_in)   begin e.cf = 2'd2; e.co = 1'b0;  end
    else if (c_out)  begin e.cf = 2'd3; e.co = 1'b1;  end
    else             begin e.cf = 2'd0; e.co = 1'b1;  end
    return e;
  endfunction

  task automatic drive(logic g, logic [NM-1:0] me, logic [NM-1:0] md, logic pi,
                       logic [NV-1:0] ve, logic [NV-1:0] vd,
                       logic ce, logic cd, logic ci, logic co, string tag);
    @(negedge clk);
    grp = g; m_en = me; m_dir = md; port_in = pi; v_en = ve; v_dir = vd;
    c_en = ce; c_dir = cd; c_in = ci; c_out = co;
    q.push_back(model(tag));
  endtask

  // monitor: result is visible just after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "mic_func", 8'(mic_func), 8'(e.mf));
        check(e.tag, "mic_oe", 8'(mic_oe), 8'(e.mo));
        check(e.tag, "mic_pd", 8'(mic_pd), 8'(e.mp));
        check(e.tag, "mic_mute", 8'(mic_mute), 8'(e.mm));
        check(e.tag, "vref_func", 8'(vref_func), 8'(e.vf));
        check(e.tag, "vref_oe", 8'(vref_oe), 8'(e.vo));
        check(e.tag, "combo_func", 8'(combo_func), 8'(e.cf));
        check(e.tag, "combo_oe", 8'(combo_oe), 8'(e.co));
      end
    end
  end

  initial begin
    #(CLK_PERIOD*50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "mic_func", 8'(mic_func), 8'h0);
    check("R1", "mic_oe", 8'(mic_oe), 8'h0);
    check("R1", "mic_pd", 8'(mic_pd), 8'h7);
    check("R1", "mic_mute", 8'(mic_mute), 8'h1);
    check("R1", "vref_func", 8'(vref_func), 8'h0);
    check("R1", "vref_oe", 8'(vref_oe), 8'h3);
    check("R1", "combo_func", 8'(combo_func), 8'h0);
    check("R1", "combo_oe", 8'(combo_oe), 8'h1);
    rst_ni = 1'b1;

    // R2 GPIO beats every other combined-pad function
    drive(1, '0, '0, 1, '0, '0, 1, 1, 1, 1, "R2");
    drive(1, '0, '0, 1, '0, '0, 1, 0, 0, 1, "R2");
    // R10 pad enables ignored without group enable
    drive(0, 3'b111, 3'b111, 1, 2'b11, 2'b11, 1, 0, 0, 0, "R10");
    // R3 receive, transmit, power-down
    drive(1, '0, '0, 1, '0, '0, 0, 0, 1, 0, "R3");
    drive(1, '0, '0, 1, '0, '0, 0, 0, 0, 1, "R3");
    drive(1, '0, '0, 1, '0, '0, 0, 0, 0, 0, "R3");
    // R4 tie: receive wins
    drive(1, '0, '0, 1, '0, '0, 0, 1, 1, 1, "R4");
    drive(0, '0, '0, 1, '0, '0, 1, 1, 1, 1, "R4");
    // R5 reference pads
    drive(1, '0, '0, 1, 2'b01, 2'b01, 0, 0, 0, 0, "R5");
    drive(1, '0, '0, 1, 2'b10, 2'b00, 0, 0, 0, 0, "R5");
    drive(0, '0, '0, 1, 2'b11, 2'b11, 0, 0, 0, 0, "R5");
    // R6 pull-down follows group enable
    drive(0, '0, '0, 1, '0, '0, 0, 0, 0, 0, "R6");
    drive(1, '0, '0, 1, '0, '0, 0, 0, 0, 0, "R6");
    // R7 mute conditions
    drive(1, '0, '0, 0, '0, '0, 0, 0, 0, 0, "R7");
    drive(1, 3'b100, 3'b100, 1, '0, '0, 0, 0, 0, 0, "R7");
    drive(1, 3'b011, 3'b010, 1, '0, '0, 0, 0, 0, 0, "R7");
    drive(0, 3'b011, 3'b010, 1, '0, '0, 0, 0, 0, 0, "R7");
    // R9 output-enable per function
    drive(1, 3'b111, 3'b101, 1, 2'b11, 2'b10, 1, 1, 0, 0, "R9");
    drive(0, '0, '0, 1, '0, '0, 0, 0, 0, 0, "R9");
    // R8 no change before the capturing edge
    drive(0, '0, '0, 1, '0, '0, 0, 0, 0, 1, "R8");
    #1;
    check("R8", "combo_func_early", 8'(combo_func), 8'h0);
    check("R8", "combo_oe_early", 8'(combo_oe), 8'h1);
    drive(0, '0, '0, 1, '0, '0, 0, 0, 1, 0, "R8");
    #1;
    check("R8", "combo_func_early", 8'(combo_func), 8'h3);

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule